// File: doc/BRIEF.md
# Raster Scan Timing Controller

This block turns a pixel clock into the timing skeleton of a raster display. A horizontal counter divides time into lines and forms the horizontal sync pulse from two compare points. A line counter walks a vertical region machine (back porch, active, front porch, sync) and forms the vertical sync pulse. The same machine keeps a framebuffer row address for the pixel fetch logic, so each active scanline knows where its pixels start.

Stored rows can be shown on several consecutive scanlines through a programmable repeat factor. The row address lives inside a circular screen buffer: when stepping past the buffer limit it folds back by the buffer size, so a scrolled screen start needs no copying. All timing thresholds and buffer geometry arrive as static configuration ports; the consumer watches `line_start`, `visible` and `line_addr`.

Top module: `scan_timing_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `hsync_n` and `vsync_n` are 1, `visible` and `line_start` are 0 and `line_addr` is 0; the region machine begins in back porch with line count 0.
- R2: The horizontal counter runs 0 up to `cfg_line_period` and wraps to 0; `line_start` is a single-cycle pulse in the cycle the counter is 0 after a wrap, so pulses are `cfg_line_period`+1 clocks apart.
- R3: `hsync_n` falls in the cycle after the counter equals `cfg_hs_begin` and rises in the cycle after it equals `cfg_hs_finish`, giving a low pulse of `cfg_hs_finish`-`cfg_hs_begin` clocks per line.
- R4: The line count increments on each horizontal sync compare event (counter equal to `cfg_hs_begin`); `visible` rises one cycle after the event that brings the count to `cfg_vis_first` and falls one cycle after the event that brings it to `cfg_front_first`.
- R5: On entry to the active region `line_addr` is loaded with `cfg_base_start`.
- R6: In the active region `line_addr` advances by `cfg_row_bytes` only on events whose new line count is an exact multiple of `cfg_row_repeat`; with a repeat of 1 it advances on every active line; otherwise it holds.
- R7: If the advanced address is greater than or equal to `cfg_base_limit`, `cfg_span` is subtracted from it.
- R8: `vsync_n` goes low at the first line start after the event reaching `cfg_vs_first` and returns high at the first line start after the event reaching `cfg_vs_last`; it changes only in a `line_start` cycle.
- R9: The event that brings the count to `cfg_vs_last` clears it to 0 and returns to back porch, so each frame spans `cfg_vs_last` lines and repeats identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_line_period | input | HW | Last horizontal counter value of a line |
| cfg_hs_begin | input | HW | Counter value starting hsync (and the line event) |
| cfg_hs_finish | input | HW | Counter value ending hsync |
| cfg_vis_first | input | VW | Line count entering the active region |
| cfg_front_first | input | VW | Line count entering the front porch |
| cfg_vs_first | input | VW | Line count entering vertical sync |
| cfg_vs_last | input | VW | Line count ending the frame |
| cfg_row_repeat | input | RW | Scanlines per stored row (at least 1) |
| cfg_base_start | input | AW | Screen start address |
| cfg_row_bytes | input | AW | Address step per stored row |
| cfg_base_limit | input | AW | Exclusive upper end of the circular buffer |
| cfg_span | input | AW | Circular buffer size |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| visible | output | 1 | Active region flag |
| line_start | output | 1 | One-cycle pulse at each line start |
| line_addr | output | AW | Current row base address |

## Verification
The bench builds the block with its default widths (12-bit horizontal, 11-bit vertical, 4-bit repeat, 24-bit address) and drives a deliberately tiny raster: 10-clock lines, a 14-line frame and a 64-byte buffer whose limit is reached on the fourth stored row. Those values bring two complete frames, the buffer fold, the vsync edges and the frame restart within a few hundred clocks. A second run with a repeat factor of 1 reaches the every-line stepping and an early fold.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        RG_BACK   = 2'd0,
        RG_ACTIVE = 2'd1,
        RG_FRONT  = 2'd2,
        RG_SYNC   = 2'd3
    } region_e;

    typedef struct packed {
        logic load;
        logic step;
    } addr_cmd_t;

    localparam int ADDR_MAX_W = 32;

    // Step a row address inside a circular buffer.
    function automatic logic [ADDR_MAX_W-1:0] fold_step(
        input logic [ADDR_MAX_W-1:0] base,
        input logic [ADDR_MAX_W-1:0] step,
        input logic [ADDR_MAX_W-1:0] limit,
        input logic [ADDR_MAX_W-1:0] span
    );
        logic [ADDR_MAX_W-1:0] sum;
        sum = base + step;
        if (sum >= limit) begin
            sum = sum - span;
        end
        return sum;
    endfunction

endpackage

// File: rtl/scan_hgen.sv
module scan_hgen #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] period,
    input  logic [HW-1:0] hs_begin,
    input  logic [HW-1:0] hs_finish,
    output logic          hsync_n,
    output logic          line_start,
    output logic          line_end,
    output logic          sync_evt
);
    logic [HW-1:0] hcnt;

    assign line_end = (hcnt == period);
    assign sync_evt = (hcnt == hs_begin);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt       <= '0;
            line_start <= 1'b0;
            hsync_n    <= 1'b1;
        end else begin
            hcnt       <= line_end ? '0 : hcnt + 1'b1;
            line_start <= line_end;
            if (sync_evt) begin
                hsync_n <= 1'b0;
            end else if (hcnt == hs_finish) begin
                hsync_n <= 1'b1;
            end
        end
    end

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (rst)
        (line_start && period != '0) |=> !line_start);

    p_hs_fall_r3: assert property (@(posedge clk) disable iff (rst)
        sync_evt |=> !hsync_n);

    p_hs_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (hcnt == hs_finish && !sync_evt) |=> hsync_n);

endmodule

// File: rtl/scan_vfsm.sv
module scan_vfsm
    import scan_pkg::*;
#(
    parameter int VW = 11,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_evt,
    input  logic          line_end,
    input  logic [VW-1:0] vis_first,
    input  logic [VW-1:0] front_first,
    input  logic [VW-1:0] vs_first,
    input  logic [VW-1:0] vs_last,
    input  logic [RW-1:0] row_repeat,
    output logic          visible,
    output logic          vsync_n,
    output addr_cmd_t     cmd
);
    region_e       region;
    logic [VW-1:0] line;
    logic [VW-1:0] line_nxt;
    logic [RW-1:0] rep_phase;
    logic [RW-1:0] rep_nxt;
    logic [RW:0]   rep_inc;
    logic          vs_target;

    always_comb begin
        line_nxt = line + 1'b1;
        rep_inc  = {1'b0, rep_phase} + 1'b1;
        rep_nxt  = (rep_inc >= {1'b0, row_repeat}) ? '0 : rep_inc[RW-1:0];
        cmd.load = sync_evt && (region == RG_BACK) && (line_nxt >= vis_first);
        cmd.step = sync_evt && (region == RG_ACTIVE) && (line_nxt < front_first)
                   && (rep_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            region    <= RG_BACK;
            line      <= '0;
            rep_phase <= '0;
            vs_target <= 1'b1;
            vsync_n   <= 1'b1;
            visible   <= 1'b0;
        end else begin
            if (line_end) begin
                vsync_n <= vs_target;
            end
            if (sync_evt) begin
                line      <= line_nxt;
                rep_phase <= rep_nxt;
                unique case (region)
                    RG_BACK: if (line_nxt >= vis_first) begin
                        region  <= RG_ACTIVE;
                        visible <= 1'b1;
                    end
                    RG_ACTIVE: if (line_nxt >= front_first) begin
                        region  <= RG_FRONT;
                        visible <= 1'b0;
                    end
                    RG_FRONT: if (line_nxt >= vs_first) begin
                        region    <= RG_SYNC;
                        vs_target <= 1'b0;
                    end
                    RG_SYNC: if (line_nxt >= vs_last) begin
                        region    <= RG_BACK;
                        line      <= '0;
                        rep_phase <= '0;
                        vs_target <= 1'b1;
                    end
                    default: region <= RG_BACK;
                endcase
            end
        end
    end

    p_vis_on_event_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(visible) |-> $past(sync_evt));

    p_vsync_at_line_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(vsync_n) |-> $past(line_end));

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (region == RG_SYNC && sync_evt && line_nxt >= vs_last) |=> (region == RG_BACK));

endmodule

// File: rtl/scan_addr.sv
module scan_addr
    import scan_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  addr_cmd_t     cmd,
    input  logic [AW-1:0] base_start,
    input  logic [AW-1:0] row_bytes,
    input  logic [AW-1:0] base_limit,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] line_addr
);
    localparam int PAD = ADDR_MAX_W - AW;

    logic [ADDR_MAX_W-1:0] stepped;

    always_comb begin
        stepped = fold_step({{PAD{1'b0}}, line_addr}, {{PAD{1'b0}}, row_bytes},
                            {{PAD{1'b0}}, base_limit}, {{PAD{1'b0}}, span});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_addr <= '0;
        end else if (cmd.load) begin
            line_addr <= base_start;
        end else if (cmd.step) begin
            line_addr <= stepped[AW-1:0];
        end
    end

    p_load_start_r5: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (line_addr == $past(base_start)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(cmd.load || cmd.step) |=> $stable(line_addr));

    p_fold_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && $stable(base_limit) && line_addr < base_limit && row_bytes <= span)
        |=> (line_addr < base_limit));

endmodule

// File: rtl/scan_timing_ctrl.sv
module scan_timing_ctrl
    import scan_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int RW = 4,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] cfg_line_period,
    input  logic [HW-1:0] cfg_hs_begin,
    input  logic [HW-1:0] cfg_hs_finish,
    input  logic [VW-1:0] cfg_vis_first,
    input  logic [VW-1:0] cfg_front_first,
    input  logic [VW-1:0] cfg_vs_first,
    input  logic [VW-1:0] cfg_vs_last,
    input  logic [RW-1:0] cfg_row_repeat,
    input  logic [AW-1:0] cfg_base_start,
    input  logic [AW-1:0] cfg_row_bytes,
    input  logic [AW-1:0] cfg_base_limit,
    input  logic [AW-1:0] cfg_span,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          visible,
    output logic          line_start,
    output logic [AW-1:0] line_addr
);
    logic      line_end;
    logic      sync_evt;
    addr_cmd_t cmd;

    u_hgen_chk: assert final (AW <= ADDR_MAX_W);

    scan_hgen #(.HW(HW)) u_hgen (
        .clk        (clk),
        .rst        (rst),
        .period     (cfg_line_period),
        .hs_begin   (cfg_hs_begin),
        .hs_finish  (cfg_hs_finish),
        .hsync_n    (hsync_n),
        .line_start (line_start),
        .line_end   (line_end),
        .sync_evt   (sync_evt)
    );

    scan_vfsm #(.VW(VW), .RW(RW)) u_vfsm (
        .clk         (clk),
        .rst         (rst),
        .sync_evt    (sync_evt),
        .line_end    (line_end),
        .vis_first   (cfg_vis_first),
        .front_first (cfg_front_first),
        .vs_first    (cfg_vs_first),
        .vs_last     (cfg_vs_last),
        .row_repeat  (cfg_row_repeat),
        .visible     (visible),
        .vsync_n     (vsync_n),
        .cmd         (cmd)
    );

    scan_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .base_start (cfg_base_start),
        .row_bytes  (cfg_row_bytes),
        .base_limit (cfg_base_limit),
        .span       (cfg_span),
        .line_addr  (line_addr)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (hsync_n && vsync_n && !visible && !line_start && line_addr == '0));

endmodule

// File: tb/sim_scan_timing_ctrl.sv
module sim_scan_timing_ctrl;
    localparam int HW = 12;
    localparam int VW = 11;
    localparam int RW = 4;
    localparam int AW = 24;

    // Expected per line count: {visible, vsync_n, addr[15:0]}
    localparam logic [17:0] EXP [14] = '{
        {1'b0, 1'b0, 16'd84},
        {1'b0, 1'b1, 16'd84},
        {1'b1, 1'b1, 16'd100},
        {1'b1, 1'b1, 16'd100},
        {1'b1, 1'b1, 16'd116},
        {1'b1, 1'b1, 16'd116},
        {1'b1, 1'b1, 16'd132},
        {1'b1, 1'b1, 16'd132},
        {1'b1, 1'b1, 16'd84},
        {1'b1, 1'b1, 16'd84},
        {1'b0, 1'b1, 16'd84},
        {1'b0, 1'b1, 16'd84},
        {1'b0, 1'b1, 16'd84},
        {1'b0, 1'b0, 16'd84}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] cfg_line_period = 12'd9;
    logic [HW-1:0] cfg_hs_begin    = 12'd2;
    logic [HW-1:0] cfg_hs_finish   = 12'd4;
    logic [VW-1:0] cfg_vis_first   = 11'd2;
    logic [VW-1:0] cfg_front_first = 11'd10;
    logic [VW-1:0] cfg_vs_first    = 11'd12;
    logic [VW-1:0] cfg_vs_last     = 11'd14;
    logic [RW-1:0] cfg_row_repeat  = 4'd2;
    logic [AW-1:0] cfg_base_start  = 24'd100;
    logic [AW-1:0] cfg_row_bytes   = 24'd16;
    logic [AW-1:0] cfg_base_limit  = 24'd148;
    logic [AW-1:0] cfg_span        = 24'd64;
    logic          hsync_n, vsync_n, visible, line_start;
    logic [AW-1:0] line_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    scan_timing_ctrl #(.HW(HW), .VW(VW), .RW(RW), .AW(AW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_line_period(cfg_line_period), .cfg_hs_begin(cfg_hs_begin),
        .cfg_hs_finish(cfg_hs_finish), .cfg_vis_first(cfg_vis_first),
        .cfg_front_first(cfg_front_first), .cfg_vs_first(cfg_vs_first),
        .cfg_vs_last(cfg_vs_last), .cfg_row_repeat(cfg_row_repeat),
        .cfg_base_start(cfg_base_start), .cfg_row_bytes(cfg_row_bytes),
        .cfg_base_limit(cfg_base_limit), .cfg_span(cfg_span),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .visible(visible),
        .line_start(line_start), .line_addr(line_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Advance to the next line_start cycle (counter 0), then to counter 4.
    task automatic next_line_mid();
        do @(negedge clk); while (!line_start);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int n;
        int lows;
        // R1: reset state, one cycle after release
        do_reset();
        chk("R1 hsync_n", hsync_n, 1);
        chk("R1 vsync_n", vsync_n, 1);
        chk("R1 visible", visible, 0);
        chk("R1 line_start", line_start, 0);
        chk("R1 line_addr", line_addr, 0);

        // Two frames walked against the table (R4 R5 R6 R7 R8 R9)
        for (int k = 1; k <= 28; k++) begin
            int v;
            next_line_mid();
            v = (k + 1) % 14;
            chk($sformatf("R4 visible line %0d", v), visible, EXP[v][17]);
            chk($sformatf("R8 vsync_n line %0d", v), vsync_n, EXP[v][16]);
            chk($sformatf("R6 R7 addr line %0d", v), line_addr, EXP[v][15:0]);
            chk("R3 hsync_n low mid pulse", hsync_n, 0);
            chk("R2 line_start single", line_start, 0);
        end

        // R2: line period; R3: hsync width
        do @(negedge clk); while (!line_start);
        n = 0;
        do begin @(negedge clk); n++; end while (!line_start);
        chk("R2 line period", n, 10);
        lows = 0;
        for (int c = 0; c < 10; c++) begin
            if (!hsync_n) lows++;
            @(negedge clk);
        end
        chk("R3 hsync width", lows, 2);

        // R5 R6 R7 with repeat factor 1
        cfg_row_repeat = 4'd1;
        do_reset();
        begin
            int exp_a [5] = '{100, 116, 132, 84, 100};
            for (int k = 1; k <= 5; k++) begin
                next_line_mid();
                chk($sformatf("R6 repeat1 addr line %0d", k + 1), line_addr, exp_a[k-1]);
            end
        end
        chk("R4 visible repeat1", visible, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule